// File: doc/BRIEF.md
# Non-Restoring Division Step Engine

This block carries out non-restoring binary division one bit per clock. Three status bits steer it: a divisor-sign bit (M), a partial-remainder sign bit (Q) and a quotient bit (T). Each step shifts the partial remainder left by one and feeds the current T into the vacated low bit. It then adds or subtracts the divisor, depending on whether the old Q matches M. The new Q comes from an exclusive-OR of the bit shifted out, the carry or borrow of that add or subtract, and M. It is not taken from a plain magnitude compare.

A start strobe loads the divisor and the partial remainder and initialises the status bits for either unsigned or signed operation. The engine then runs one step per cycle for as many steps as the data width. Each step's T bit is shifted into a quotient register, and a one-cycle done pulse marks the end of the run. A single-step strobe, issued while idle, performs exactly one step on the operands currently on the input ports, using the status bits as they stand. A host can drive the algorithm step by step this way.

Top module: `divstep_engine`

## Requirements
- R1: After reset, rem_o and quot_o are zero, m_o, q_o and t_o are 0, and busy_o and done_o are 0.
- R2: An accepted start with signed_i = 0 loads rem_i into the remainder register, clears quot_o and clears M, Q and T. These values are visible in the cycle after the start edge, with busy_o = 1.
- R3: An accepted start with signed_i = 1 sets Q to bit 31 of rem_i, M to bit 31 of divisor_i and T to Q XOR M. The remainder is loaded as in R2.
- R4: A step forms the shifted value {rem[30:0], T}. It subtracts the divisor from that value when the old Q equals M, and adds the divisor otherwise. The 32-bit result becomes the new remainder.
- R5: After a step, Q equals the old remainder bit 31 XOR the carry/borrow of that add/subtract XOR M, where borrow is 1 when the subtrahend exceeds the shifted value. M is unchanged.
- R6: After a step, T is 1 exactly when the new Q equals M.
- R7: After a start edge, the engine performs one step per clock for 32 clocks with busy_o = 1. In the cycle after the 32nd step, busy_o = 0 and done_o = 1 for exactly one cycle.
- R8: During a run, each step shifts quot_o left by one and places the step's new T in bit 0. After the run, bit 0 holds the last step's T and bit 31 the first step's T.
- R9: A step strobe while idle (and without start) performs one step on rem_i and divisor_i with the current M, Q and T. quot_o is left unchanged, and neither busy_o nor done_o is raised.
- R10: A start or step strobe that arrives while busy_o = 1 is ignored. The run's results and timing are the same as without it.
- R11: When start and step strobes arrive in the same idle cycle, the start takes precedence and no single step is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Load operands, initialise status bits and begin a full run |
| step_i | input | 1 | Perform one step on the port operands when idle |
| signed_i | input | 1 | Selects signed initialisation on start |
| divisor_i | input | 32 | Divisor operand |
| rem_i | input | 32 | Partial remainder (dividend) operand |
| rem_o | output | 32 | Current partial remainder |
| quot_o | output | 32 | Quotient register built from the T bits of a run |
| m_o | output | 1 | Divisor-sign status bit |
| q_o | output | 1 | Remainder-sign status bit |
| t_o | output | 1 | Quotient status bit |
| busy_o | output | 1 | High while a run is in progress |
| done_o | output | 1 | One-cycle pulse after the last step of a run |

## Verification
The bench builds the engine with its default width of 32, so a run is the full 32 steps. This brings the last-step boundary of the step counter, the done-pulse timing and the complete 32-bit quotient into reach. Runs cover unsigned and signed operands with each sign combination and a zero divisor, so both the add and subtract paths occur with carry and borrow both set and clear. Single steps from hand-worked values pin down each step rule. Strobes injected mid-run, and a simultaneous start and step, cover the ignore and precedence rules.

// File: rtl/divstep_pkg.sv
// Shared types for the division step engine.
// Assumes: nothing beyond IEEE 1800-2017.
package divstep_pkg;

    // Status bits steering one division step
    typedef struct packed {
        logic m;   // divisor sign
        logic q;   // partial-remainder sign
        logic t;   // quotient bit
    } dstat_t;

    localparam dstat_t DSTAT_CLEAR = '{m: 1'b0, q: 1'b0, t: 1'b0};

endpackage

// File: rtl/divstep_core.sv
// One non-restoring division step, purely combinational.
// A single adder serves both add and subtract: the divisor is inverted and
// a carry-in of one is applied when subtracting. The borrow is the inverse
// of the adder carry-out in that case.
// Assumes: WIDTH >= 2.
module divstep_core
    import divstep_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] rem_i,
    input  logic [WIDTH-1:0] dvs_i,
    input  dstat_t           st_i,
    output logic [WIDTH-1:0] rem_o,
    output dstat_t           st_o
);

    logic             do_sub;
    logic [WIDTH-1:0] shifted;
    logic [WIDTH-1:0] operand;
    logic [WIDTH:0]   sum;
    logic             cy_flag;
    logic             new_q;

    // Shift, pick the operation, add, and derive the new status bits
    always_comb begin
        do_sub  = (st_i.q == st_i.m);
        shifted = {rem_i[WIDTH-2:0], st_i.t};
        operand = do_sub ? ~dvs_i : dvs_i;
        sum     = {1'b0, shifted} + {1'b0, operand} + {{WIDTH{1'b0}}, do_sub};
        cy_flag = do_sub ? ~sum[WIDTH] : sum[WIDTH];
        new_q   = rem_i[WIDTH-1] ^ cy_flag ^ st_i.m;
        rem_o   = sum[WIDTH-1:0];
        st_o.m  = st_i.m;
        st_o.q  = new_q;
        st_o.t  = (new_q == st_i.m);
    end

endmodule

// File: rtl/divstep_init.sv
// Computes the status bits loaded at the start of a run.
// Unsigned: all clear. Signed: Q from the dividend sign, M from the divisor
// sign, T as their exclusive-OR.
// Assumes: WIDTH >= 2.
module divstep_init
    import divstep_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             signed_mode_i,
    input  logic [WIDTH-1:0] dividend_i,
    input  logic [WIDTH-1:0] divisor_i,
    output dstat_t           st_o
);

    // Select the initial status for the chosen signedness
    always_comb begin
        if (signed_mode_i) begin
            st_o.q = dividend_i[WIDTH-1];
            st_o.m = divisor_i[WIDTH-1];
            st_o.t = dividend_i[WIDTH-1] ^ divisor_i[WIDTH-1];
        end else begin
            st_o = DSTAT_CLEAR;
        end
    end

endmodule

// File: rtl/divstep_seq.sv
// Run sequencer: accepts strobes only when idle, counts STEPS busy cycles
// and raises a one-cycle done pulse after the last one. Start outranks step.
// Assumes: STEPS >= 2, synchronous active-low reset.
module divstep_seq #(
    parameter int STEPS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic step_i,
    output logic load_o,
    output logic single_o,
    output logic run_o,
    output logic busy_o,
    output logic done_o
);

    localparam int             CNT_W = $clog2(STEPS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STEPS - 1);

    logic             busy_q;
    logic             done_q;
    logic [CNT_W-1:0] cnt_q;

    assign load_o   = start_i && !busy_q;
    assign single_o = step_i && !start_i && !busy_q;
    assign run_o    = busy_q;
    assign busy_o   = busy_q;
    assign done_o   = done_q;

    // Track busy window, step count and end-of-run pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            cnt_q  <= '0;
        end else if (load_o) begin
            busy_q <= 1'b1;
            done_q <= 1'b0;
            cnt_q  <= '0;
        end else if (busy_q) begin
            if (cnt_q == LAST) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
            end else begin
                cnt_q  <= cnt_q + 1'b1;
                done_q <= 1'b0;
            end
        end else begin
            done_q <= 1'b0;
        end
    end

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R7
    done_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (!busy_q && $past(busy_q)));

    // R7
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && cnt_q != LAST) |=> busy_q);

    // R10
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && cnt_q != LAST && start_i) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/divstep_engine.sv
// Division step engine top: holds the remainder, divisor, status bits and
// quotient, and routes either the stored or the port operands into the
// step core. A run performs WIDTH steps; a single step uses port operands.
// Assumes: WIDTH >= 2, synchronous active-low reset.
module divstep_engine
    import divstep_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             step_i,
    input  logic             signed_i,
    input  logic [WIDTH-1:0] divisor_i,
    input  logic [WIDTH-1:0] rem_i,
    output logic [WIDTH-1:0] rem_o,
    output logic [WIDTH-1:0] quot_o,
    output logic             m_o,
    output logic             q_o,
    output logic             t_o,
    output logic             busy_o,
    output logic             done_o
);

    localparam int MSB = WIDTH - 1;

    logic             load;
    logic             single;
    logic             run;
    dstat_t           st_q;
    dstat_t           st_init;
    dstat_t           st_next;
    logic [WIDTH-1:0] rem_q;
    logic [WIDTH-1:0] div_q;
    logic [WIDTH-1:0] quot_q;
    logic [WIDTH-1:0] core_src;
    logic [WIDTH-1:0] core_div;
    logic [WIDTH-1:0] core_rem;

    divstep_seq #(.STEPS(WIDTH)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .step_i   (step_i),
        .load_o   (load),
        .single_o (single),
        .run_o    (run),
        .busy_o   (busy_o),
        .done_o   (done_o)
    );

    divstep_init #(.WIDTH(WIDTH)) u_init (
        .signed_mode_i (signed_i),
        .dividend_i    (rem_i),
        .divisor_i     (divisor_i),
        .st_o          (st_init)
    );

    // Single steps take port operands; run steps take stored ones
    assign core_src = single ? rem_i : rem_q;
    assign core_div = single ? divisor_i : div_q;

    divstep_core #(.WIDTH(WIDTH)) u_core (
        .rem_i (core_src),
        .dvs_i (core_div),
        .st_i  (st_q),
        .rem_o (core_rem),
        .st_o  (st_next)
    );

    // Update datapath registers on load, run step or single step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            div_q  <= '0;
            quot_q <= '0;
            st_q   <= DSTAT_CLEAR;
        end else if (load) begin
            rem_q  <= rem_i;
            div_q  <= divisor_i;
            quot_q <= '0;
            st_q   <= st_init;
        end else if (run) begin
            rem_q  <= core_rem;
            quot_q <= {quot_q[WIDTH-2:0], st_next.t};
            st_q   <= st_next;
        end else if (single) begin
            rem_q  <= core_rem;
            st_q   <= st_next;
        end
    end

    assign rem_o  = rem_q;
    assign quot_o = quot_q;
    assign m_o    = st_q.m;
    assign q_o    = st_q.q;
    assign t_o    = st_q.t;

    // R2 R3
    init_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> ((rem_q == $past(rem_i)) && (quot_q == '0)
                  && (st_q.m == ($past(signed_i) && $past(divisor_i[MSB])))
                  && (st_q.q == ($past(signed_i) && $past(rem_i[MSB])))));

    // R6
    t_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run || single) |=> (st_q.t == (st_q.q == st_q.m)));

    // R8
    quot_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> (quot_q == {$past(quot_q[WIDTH-2:0]), st_q.t}));

    // R9
    single_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        single |=> ($stable(quot_q) && !busy_o && !done_o));

    // R10
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(div_q));

endmodule

// File: tb/tb_divstep_engine.sv
// Directed bench for the division step engine; one task per scenario.
module tb_divstep_engine;

    localparam int W          = 32;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         start_i, step_i, signed_i;
    logic [W-1:0] divisor_i, rem_i;
    logic [W-1:0] rem_o, quot_o;
    logic         m_o, q_o, t_o, busy_o, done_o;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;

    divstep_engine #(.WIDTH(W)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .step_i(step_i),
        .signed_i(signed_i), .divisor_i(divisor_i), .rem_i(rem_i),
        .rem_o(rem_o), .quot_o(quot_o), .m_o(m_o), .q_o(q_o), .t_o(t_o),
        .busy_o(busy_o), .done_o(done_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            failures = failures + 1;
            $display("FAIL R7 watchdog: actual=still running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            failures = failures + 1;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference step written with magnitude compares: {rem, m, q, t}
    function automatic logic [W+2:0] ref_step(input logic [W-1:0] r, input logic [W-1:0] d,
                                              input logic m, input logic q, input logic t);
        logic [W-1:0] x, y;
        logic c, nq;
        x = {r[W-2:0], t};
        if (q == m) begin
            y = x - d;
            c = (d > x);
        end else begin
            y = x + d;
            c = (y < x);
        end
        nq = r[W-1] ^ c ^ m;
        return {y, m, nq, (nq == m)};
    endfunction

    function automatic logic [63:0] snap();
        return {27'd0, rem_o, m_o, q_o, t_o, busy_o, done_o};
    endfunction

    task automatic t_reset();
        rst_n = 1'b0; start_i = 0; step_i = 0; signed_i = 0;
        divisor_i = '0; rem_i = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk("R1 reset state", {snap()[36:0], quot_o}, {37'd0, 32'd0});
    endtask

    // Hand-worked single steps covering subtract, add, T=0 and T=1
    task automatic t_single_hand();
        logic [W-1:0] q_before;
        q_before = quot_o;
        rem_i = 32'h0000_0001; divisor_i = 32'h0000_0003; step_i = 1'b1;
        tick(); step_i = 1'b0;
        chk("R4 R5 R9 subtract step", snap(), {27'd0, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0});
        rem_i = 32'h8000_0004; divisor_i = 32'h0000_0003; step_i = 1'b1;
        tick(); step_i = 1'b0;
        chk("R4 R5 R6 add step", snap(), {27'd0, 32'h0000_000B, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0});
        rem_i = 32'h7FFF_FFFF; divisor_i = 32'h0000_0001; step_i = 1'b1;
        tick(); step_i = 1'b0;
        chk("R5 R6 add step T set", snap(), {27'd0, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0});
        chk("R9 quotient untouched by single steps", {32'd0, quot_o}, {32'd0, q_before});
    endtask

    // Single step from whatever status the outputs show
    task automatic t_single_model(input logic [W-1:0] r, input logic [W-1:0] d);
        logic [W+2:0] e;
        e = ref_step(r, d, m_o, q_o, t_o);
        rem_i = r; divisor_i = d; step_i = 1'b1;
        tick(); step_i = 1'b0;
        chk("R9 single step from current status", snap(), {27'd0, e, 1'b0, 1'b0});
    endtask

    // Full run; disturb >= 0 injects strobes at that step, both raises step with start
    task automatic t_run(input logic sg, input logic [W-1:0] r, input logic [W-1:0] d,
                         input int disturb, input logic both);
        logic         em, eq, et;
        logic [W-1:0] er, eqt;
        logic [W+2:0] e;
        em = sg & d[W-1];
        eq = sg & r[W-1];
        et = em ^ eq;
        signed_i = sg; rem_i = r; divisor_i = d; start_i = 1'b1; step_i = both;
        tick();
        start_i = 1'b0; step_i = 1'b0;
        if (both)
            chk("R11 start outranks step", snap(), {27'd0, r, em, eq, et, 1'b1, 1'b0});
        else if (sg)
            chk("R3 signed init", snap(), {27'd0, r, em, eq, et, 1'b1, 1'b0});
        else
            chk("R2 unsigned init", snap(), {27'd0, r, em, eq, et, 1'b1, 1'b0});
        chk("R2 quotient cleared", {32'd0, quot_o}, 64'd0);
        er = r; eqt = '0;
        for (int k = 0; k < W; k++) begin
            if (k == disturb) begin
                start_i = 1'b1; step_i = 1'b1; signed_i = ~sg;
                rem_i = ~r; divisor_i = ~d;
            end
            e = ref_step(er, d, em, eq, et);
            {er, em, eq, et} = e;
            eqt = {eqt[W-2:0], et};
            tick();
            start_i = 1'b0; step_i = 1'b0;
            chk(k == disturb ? "R10 R4 R5 R6 step under strobe" : "R4 R5 R6 R7 run step",
                snap(), {27'd0, er, em, eq, et, (k != W - 1), (k == W - 1)});
        end
        chk(disturb >= 0 ? "R8 R10 quotient" : "R8 quotient", {32'd0, quot_o}, {32'd0, eqt});
        tick();
        chk("R7 done one cycle", {62'd0, busy_o, done_o}, 64'd0);
    endtask

    initial begin
        t_reset();
        t_single_hand();
        t_run(1'b0, 32'h1234_5678, 32'h0000_9ABC, -1, 1'b0);
        t_single_model(32'hDEAD_BEEF, 32'h0001_0001);
        t_run(1'b1, 32'hF000_0000, 32'h0000_0007, -1, 1'b0);
        t_run(1'b1, 32'h0000_0100, 32'hFFFF_FFF9, -1, 1'b0);
        t_run(1'b1, 32'h8765_4321, 32'h8000_0001, -1, 1'b0);
        t_run(1'b0, 32'hFFFF_FFFF, 32'h0000_0000, -1, 1'b0);
        t_run(1'b0, 32'h0ABC_DEF0, 32'h0000_1234, 10, 1'b0);
        t_run(1'b1, 32'hC000_0003, 32'h0000_0005, 31, 1'b0);
        t_run(1'b0, 32'h0000_00FF, 32'h0000_0010, -1, 1'b1);
        t_single_model(32'h4000_0000, 32'h3000_0000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule